// File: doc/BRIEF.md
# Cascadable Dual 16-bit Counter

Two 16-bit up/down counter channels share one register write port. Each channel picks its count source with a 3-bit clock-select field and a mode bit. The source can be a tap of a shared internal prescaler, or a quadrature (phase-counting) decoder driven by that channel's pair of encoder inputs. The upper channel (channel 1) can also select the carry and borrow of the lower channel (channel 0). In that setting the two counters behave as one 32-bit counter, with channel 1 as the high half.

A carry into the upper half happens whenever the lower half steps up from its all-ones value. A borrow happens whenever the lower half steps down from zero. A borrow can only arise while the lower channel is in quadrature mode, because every other source only counts up. Both halves move on the same clock edge, so the two count outputs always read as a consistent 32-bit value. An upper channel placed in quadrature mode counts its own encoder and disregards the cascade selection. Each channel keeps sticky wrap-up and wrap-down flags, which software clears by writing ones.

Top module: `cascade_counter32`

## Requirements
- R1: After reset both counts and all four flags are zero. Both channels come up with mode 0 and select 4, so no count event occurs until software writes a control value.
- R2: `wr_addr[2]` chooses the channel and `wr_addr[1:0]` the register: 0 = control (`wr_data[2:0]` select, `wr_data[3]` quadrature mode), 1 = count load, 2 = flag clear. A count load appears on `count_o` one cycle after the write. Any count event in that same cycle is dropped, along with the carry, borrow and flag it would have produced.
- R3: With mode 0, selects 0, 1, 2 and 3 advance the count by exactly one per 1, 4, 16 and 64 clock cycles.
- R4: With mode 0, selects 4, 5 and 6 hold the count on either channel. Select 7 holds it on channel 0.
- R5: With channel 1 on select 7 and mode 0, a channel 0 step from 0xFFFF to 0x0000 increments channel 1 on the same clock edge.
- R6: A channel 0 step from 0x0000 to 0xFFFF, possible only in quadrature mode, decrements a cascaded channel 1 on the same edge. With channel 0 in mode 0 its count never decreases.
- R7: In quadrature mode, each single-input transition of the synchronised (A,B) pair steps the count by one, 3 cycles after the input changes. An edge on A steps up when A differs from B after the edge, and down otherwise. An edge on B steps up when A equals B after the edge, and down otherwise.
- R8: A sample in which A and B both change leaves the count unchanged.
- R9: A channel 1 in quadrature mode ignores its select field, including select 7. It counts only its own encoder.
- R10: The wrap-up flag (`ovf_o`) sets on a step from all-ones to zero, and the wrap-down flag (`unf_o`) on a step from zero to all-ones. Each flag stays set until a flag-clear write with bit 0 (wrap-up) or bit 1 (wrap-down) set. A new wrap in the clearing cycle wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Channel (bit 2) and register (bits 1:0) |
| wr_data | input | 16 | Write data |
| enc_a | input | 2 | Encoder phase A, one bit per channel |
| enc_b | input | 2 | Encoder phase B, one bit per channel |
| count_o | output | 2x16 | Count of each channel; index 1 is the upper half |
| ovf_o | output | 2 | Sticky wrap-up flag per channel |
| unf_o | output | 2 | Sticky wrap-down flag per channel |

## Verification
Each result has a fixed latency:
- A count load or control write takes effect one cycle after it is driven.
- An internal-clock count first appears two cycles after its control write.
- A quadrature step lands three cycles after the encoder input changes, because of two synchroniser flops and one edge-detect flop.
- Cascade carries and borrows land on the same edge as the lower wrap.

The driver computes each expected value together with the exact cycle it is due and queues them both. The monitor compares only in that cycle, one nanosecond after the edge. Prescaler rates are checked over whole windows of 16, 64 and 128 cycles, so the free-running prescaler phase cannot shift the result.

// File: rtl/cc_pkg.sv
package cc_pkg;
  localparam int CSEL_W = 3;
  localparam logic [CSEL_W-1:0] CS_HOLD = 3'd4;
  localparam logic [CSEL_W-1:0] CS_CASC = 3'd7;
  localparam logic [1:0] RG_CTRL = 2'd0;
  localparam logic [1:0] RG_LOAD = 2'd1;
  localparam logic [1:0] RG_FCLR = 2'd2;

  typedef struct packed {
    logic              quad;
    logic [CSEL_W-1:0] sel;
  } chan_ctrl_t;
endpackage

// File: rtl/cc_prescale.sv
module cc_prescale #(
  parameter int N_DIV    = 4,
  parameter int STEP_LOG = 2
) (
  input  logic             clk,
  input  logic             rst,
  output logic [N_DIV-1:0] tick
);
  localparam int PW = STEP_LOG * (N_DIV - 1);

  logic [PW-1:0] pre;

  always_ff @(posedge clk) begin
    if (rst) pre <= '0;
    else     pre <= pre + 1'b1;
  end

  // tap k fires once every 2^(STEP_LOG*k) cycles
  for (genvar k = 0; k < N_DIV; k++) begin : g_tap
    if (k == 0) begin : g_every
      assign tick[k] = 1'b1;
    end else begin : g_div
      assign tick[k] = &pre[STEP_LOG*k-1:0];
    end
  end
endmodule

// File: rtl/cc_quad_dec.sv
module cc_quad_dec #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic enc_a,
  input  logic enc_b,
  output logic step_up,
  output logic step_dn
);
  logic [SYNC_STAGES-1:0] sa, sb;
  logic pa, pb;
  logic a_s, b_s, da, db, dir;

  always_ff @(posedge clk) begin
    if (rst) begin
      sa <= '0;
      sb <= '0;
      pa <= 1'b0;
      pb <= 1'b0;
    end else begin
      sa <= {sa[SYNC_STAGES-2:0], enc_a};
      sb <= {sb[SYNC_STAGES-2:0], enc_b};
      pa <= sa[SYNC_STAGES-1];
      pb <= sb[SYNC_STAGES-1];
    end
  end

  assign a_s = sa[SYNC_STAGES-1];
  assign b_s = sb[SYNC_STAGES-1];
  assign da  = a_s ^ pa;
  assign db  = b_s ^ pb;

  always_comb begin
    step_up = 1'b0;
    step_dn = 1'b0;
    dir     = 1'b0;
    if (da ^ db) begin
      dir     = da ? (a_s ^ b_s) : ~(a_s ^ b_s);
      step_up = dir;
      step_dn = ~dir;
    end
  end
endmodule

// File: rtl/cc_channel.sv
module cc_channel
  import cc_pkg::*;
#(
  parameter int CW       = 16,
  parameter int N_DIV    = 4,
  parameter bit HAS_CASC = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctrl_we,
  input  logic             load_we,
  input  logic             fclr_we,
  input  logic [CW-1:0]    wr_data,
  input  logic [N_DIV-1:0] tick,
  input  logic             casc_up,
  input  logic             casc_dn,
  input  logic             q_up,
  input  logic             q_dn,
  output logic [CW-1:0]    count,
  output logic             ovf,
  output logic             unf,
  output logic             carry,
  output logic             borrow,
  output chan_ctrl_t       ctrl
);
  localparam int SW = (N_DIV > 1) ? $clog2(N_DIV) : 1;

  logic ev_up, ev_dn;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl.quad <= 1'b0;
      ctrl.sel  <= CS_HOLD;
    end else if (ctrl_we) begin
      ctrl.quad <= wr_data[CSEL_W];
      ctrl.sel  <= wr_data[CSEL_W-1:0];
    end
  end

  always_comb begin
    ev_up = 1'b0;
    ev_dn = 1'b0;
    if (ctrl.quad) begin
      ev_up = q_up;
      ev_dn = q_dn;
    end else if (HAS_CASC && ctrl.sel == CS_CASC) begin
      ev_up = casc_up;
      ev_dn = casc_dn;
    end else if (ctrl.sel < CSEL_W'(N_DIV)) begin
      ev_up = tick[ctrl.sel[SW-1:0]];
    end
  end

  assign carry  = ev_up & (count == '1) & ~load_we;
  assign borrow = ev_dn & (count == '0) & ~load_we;

  always_ff @(posedge clk) begin
    if (rst)          count <= '0;
    else if (load_we) count <= wr_data;
    else if (ev_up)   count <= count + 1'b1;
    else if (ev_dn)   count <= count - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf <= 1'b0;
      unf <= 1'b0;
    end else begin
      ovf <= carry  | (ovf & ~(fclr_we & wr_data[0]));
      unf <= borrow | (unf & ~(fclr_we & wr_data[1]));
    end
  end
endmodule

// File: rtl/cascade_counter32.sv
module cascade_counter32
  import cc_pkg::*;
#(
  parameter int CW          = 16,
  parameter int N_CH        = 2,
  parameter int N_DIV       = 4,
  parameter int DIV_LOG     = 2,
  parameter int SYNC_STAGES = 2,
  localparam int CH_W       = (N_CH > 1) ? $clog2(N_CH) : 1,
  localparam int AW         = CH_W + 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [AW-1:0]            wr_addr,
  input  logic [CW-1:0]            wr_data,
  input  logic [N_CH-1:0]          enc_a,
  input  logic [N_CH-1:0]          enc_b,
  output logic [N_CH-1:0][CW-1:0]  count_o,
  output logic [N_CH-1:0]          ovf_o,
  output logic [N_CH-1:0]          unf_o
);
  logic [N_DIV-1:0]              tick;
  logic [N_CH-1:0]               carry, borrow, cin_up, cin_dn;
  logic [N_CH-1:0]               q_up, q_dn;
  logic [N_CH-1:0][CSEL_W-1:0]   sel_q;
  logic [N_CH-1:0]               quad_q;
  chan_ctrl_t                    ctrl_w [N_CH];
  logic [CH_W-1:0]               wr_ch;
  logic [1:0]                    wr_rg;

  assign wr_ch = wr_addr[AW-1:2];
  assign wr_rg = wr_addr[1:0];

  cc_prescale #(.N_DIV(N_DIV), .STEP_LOG(DIV_LOG)) u_pre (
    .clk(clk), .rst(rst), .tick(tick)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    logic hit;
    assign hit = wr_en && (wr_ch == CH_W'(i));

    if (i == 0) begin : g_first
      assign cin_up[i] = 1'b0;
      assign cin_dn[i] = 1'b0;
    end else begin : g_chain
      assign cin_up[i] = carry[i-1];
      assign cin_dn[i] = borrow[i-1];
    end

    cc_quad_dec #(.SYNC_STAGES(SYNC_STAGES)) u_qd (
      .clk(clk), .rst(rst), .enc_a(enc_a[i]), .enc_b(enc_b[i]),
      .step_up(q_up[i]), .step_dn(q_dn[i])
    );

    cc_channel #(.CW(CW), .N_DIV(N_DIV), .HAS_CASC(i > 0)) u_chan (
      .clk(clk), .rst(rst),
      .ctrl_we(hit && wr_rg == RG_CTRL),
      .load_we(hit && wr_rg == RG_LOAD),
      .fclr_we(hit && wr_rg == RG_FCLR),
      .wr_data(wr_data), .tick(tick),
      .casc_up(cin_up[i]), .casc_dn(cin_dn[i]),
      .q_up(q_up[i]), .q_dn(q_dn[i]),
      .count(count_o[i]), .ovf(ovf_o[i]), .unf(unf_o[i]),
      .carry(carry[i]), .borrow(borrow[i]), .ctrl(ctrl_w[i])
    );

    assign sel_q[i]  = ctrl_w[i].sel;
    assign quad_q[i] = ctrl_w[i].quad;
  end
endmodule

// File: rtl/cascade_counter32_chk.sv
module cascade_counter32_chk #(
  parameter int CW   = 16,
  parameter int N_CH = 2,
  parameter int AW   = 3
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    wr_en,
  input logic [AW-1:0]           wr_addr,
  input logic [CW-1:0]           wr_data,
  input logic [N_CH-1:0][CW-1:0] count_o,
  input logic [N_CH-1:0]         ovf_o,
  input logic [N_CH-1:0]         unf_o,
  input logic [N_CH-1:0][2:0]    sel_q,
  input logic [N_CH-1:0]         quad_q
);
  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en && wr_addr == AW'(1)) |-> count_o[0] == $past(wr_data));

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    ($past(!wr_en) && $past(!quad_q[0]) && $past(sel_q[0] >= 3'd4))
      |-> count_o[0] == $past(count_o[0]));

  assert_no_down_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(!wr_en) && $past(!quad_q[0]))
      |-> !($past(count_o[0]) == '0 && count_o[0] == '1));

  assert_wrap_flag_R10: assert property (@(posedge clk) disable iff (rst)
    ($past(!wr_en) && $past(count_o[0]) == '1 && count_o[0] == '0) |-> ovf_o[0]);

  assert_sticky_ovf_R10: assert property (@(posedge clk) disable iff (rst)
    ($past(ovf_o[0]) && $past(!wr_en)) |-> ovf_o[0]);

  assert_sticky_unf_R10: assert property (@(posedge clk) disable iff (rst)
    ($past(unf_o[0]) && $past(!wr_en)) |-> unf_o[0]);

  if (N_CH > 1) begin : g_casc
    assert_carry_R5: assert property (@(posedge clk) disable iff (rst)
      ($past(!wr_en) && $past(sel_q[1] == 3'd7 && !quad_q[1])
        && $past(count_o[0]) == '1 && count_o[0] == '0)
        |-> count_o[1] == CW'($past(count_o[1]) + 1'b1));
  end
endmodule

bind cascade_counter32 cascade_counter32_chk #(.CW(CW), .N_CH(N_CH), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .count_o(count_o), .ovf_o(ovf_o), .unf_o(unf_o), .sel_q(sel_q), .quad_q(quad_q)
);

// File: tb/test_cascade_counter32.sv
module test_cascade_counter32;
  timeunit 1ns;
  timeprecision 1ps;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             wr_en = 1'b0;
  logic [2:0]       wr_addr = '0;
  logic [15:0]      wr_data = '0;
  logic [1:0]       enc_a = '0, enc_b = '0;
  logic [1:0][15:0] cnt;
  logic [1:0]       ovf, unf;

  int nchk = 0, nfail = 0, cyc = 0;
  bit done = 0;

  typedef struct {
    int          due;
    int          ch;
    int          kind;   // 0 count, 1 wrap-up flag, 2 wrap-down flag
    logic [15:0] val;
    string       req;
  } exp_t;
  exp_t sbq[$];

  localparam logic [2:0] LO_CTRL = 3'b000, LO_LOAD = 3'b001, LO_FCLR = 3'b010;
  localparam logic [2:0] HI_CTRL = 3'b100, HI_LOAD = 3'b101;

  cascade_counter32 i_cascade_counter32 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .enc_a(enc_a), .enc_b(enc_b), .count_o(cnt), .ovf_o(ovf), .unf_o(unf)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] observe(int ch, int kind);
    if (kind == 0) return cnt[ch];
    if (kind == 1) return {15'd0, ovf[ch]};
    return {15'd0, unf[ch]};
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_in(int d, int ch, int kind, logic [15:0] v, string req);
    exp_t e;
    e.due = cyc + d; e.ch = ch; e.kind = kind; e.val = v; e.req = req;
    sbq.push_back(e);
  endtask

  // monitor: compares each queued item in the cycle it is due
  initial forever begin
    @(posedge clk); #1;
    for (int i = sbq.size() - 1; i >= 0; i--) begin
      if (sbq[i].due == cyc) begin
        chk(sbq[i].req, observe(sbq[i].ch, sbq[i].kind), sbq[i].val);
        sbq.delete(i);
      end else if (sbq[i].due < cyc) begin
        chk({sbq[i].req, " missed"}, 16'hDEAD, sbq[i].val);
        sbq.delete(i);
      end
    end
  end

  task automatic waitn(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic enc(int ch, logic a, logic b);
    enc_a[ch] = a; enc_b[ch] = b;
  endtask

  initial begin
    logic [15:0] v0;
    waitn(4);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 lo count", cnt[0], 16'h0);
    chk("R1 hi count", cnt[1], 16'h0);
    chk("R1 flags", {12'd0, ovf, unf}, 16'h0);
    waitn(5);
    chk("R1 idle after reset", cnt[0], 16'h0);

    // cascade setup, R2 loads
    wr(HI_CTRL, 16'h0007);
    expect_in(1, 1, 0, 16'h0010, "R2 hi load");
    wr(HI_LOAD, 16'h0010);
    expect_in(1, 0, 0, 16'hFFFD, "R2 lo load");
    wr(LO_LOAD, 16'hFFFD);

    // R3 div1 counting into overflow, R5 carry
    expect_in(3, 0, 0, 16'hFFFF, "R3 lo div1");
    expect_in(3, 1, 0, 16'h0010, "R5 hi before carry");
    expect_in(3, 0, 1, 16'h0000, "R10 flag before wrap");
    expect_in(4, 0, 0, 16'h0000, "R5 lo wrap");
    expect_in(4, 1, 0, 16'h0011, "R5 hi carry");
    expect_in(4, 0, 1, 16'h0001, "R10 wrap-up flag");
    wr(LO_CTRL, 16'h0000);
    waitn(2);
    expect_in(5, 0, 0, 16'h0000, "R4 lo held by select 4");
    expect_in(5, 1, 0, 16'h0011, "R4 hi unchanged");
    wr(LO_CTRL, 16'h0004);
    waitn(5);

    // R10 sticky then cleared
    chk("R10 sticky wrap-up", {15'd0, ovf[0]}, 16'h1);
    expect_in(1, 0, 1, 16'h0000, "R10 clear");
    wr(LO_FCLR, 16'h0001);

    // quadrature on lower, borrow into upper
    wr(LO_CTRL, 16'h000C);
    expect_in(1, 0, 0, 16'h0001, "R2 lo load quad");
    wr(LO_LOAD, 16'h0001);
    expect_in(2, 0, 0, 16'h0001, "R7 not before 3 cycles");
    expect_in(3, 0, 0, 16'h0000, "R7 B edge down");
    enc(0, 1'b0, 1'b1); waitn(4);
    expect_in(3, 0, 0, 16'hFFFF, "R6 lo wrap down");
    expect_in(3, 1, 0, 16'h0010, "R6 hi borrow");
    expect_in(3, 0, 2, 16'h0001, "R10 wrap-down flag");
    enc(0, 1'b1, 1'b1); waitn(4);
    expect_in(3, 0, 0, 16'h0000, "R7 A edge up");
    expect_in(3, 1, 0, 16'h0011, "R5 carry from quad");
    expect_in(3, 0, 1, 16'h0001, "R10 wrap-up quad");
    enc(0, 1'b0, 1'b1); waitn(4);
    expect_in(3, 0, 0, 16'h0000, "R8 both change");
    expect_in(6, 0, 0, 16'h0000, "R8 both change later");
    expect_in(6, 1, 0, 16'h0011, "R8 hi untouched");
    enc(0, 1'b1, 1'b0); waitn(7);

    // R9 upper in quadrature ignores cascade
    wr(HI_CTRL, 16'h000F);
    expect_in(3, 0, 0, 16'h0001, "R7 B edge up");
    enc(0, 1'b1, 1'b1); waitn(4);
    expect_in(3, 0, 0, 16'h0000, "R7 B edge down");
    enc(0, 1'b1, 1'b0); waitn(4);
    expect_in(3, 0, 0, 16'hFFFF, "R9 lo wraps down");
    expect_in(3, 1, 0, 16'h0011, "R9 hi no borrow");
    expect_in(6, 1, 0, 16'h0011, "R9 hi still no borrow");
    enc(0, 1'b0, 1'b0); waitn(7);
    expect_in(3, 1, 0, 16'h0012, "R9 hi own encoder");
    enc(1, 1'b1, 1'b0); waitn(4);

    // R2 load suppresses same-cycle count and its wrap
    expect_in(1, 0, 1, 16'h0000, "R10 clear both");
    expect_in(1, 0, 2, 16'h0000, "R10 clear both");
    wr(LO_FCLR, 16'h0003);
    wr(LO_CTRL, 16'h0000);
    expect_in(1, 0, 0, 16'h0100, "R2 load wins over count");
    expect_in(2, 0, 0, 16'h0101, "R2 counting resumes");
    expect_in(2, 0, 1, 16'h0000, "R2 no wrap flag from dropped step");
    wr(LO_LOAD, 16'h0100);
    waitn(3);

    // R3 prescaler rates over whole windows
    wr(LO_CTRL, 16'h0001); waitn(2);
    v0 = cnt[0]; waitn(16);
    chk("R3 div4 rate", cnt[0] - v0, 16'd4);
    wr(LO_CTRL, 16'h0002); waitn(2);
    v0 = cnt[0]; waitn(64);
    chk("R3 div16 rate", cnt[0] - v0, 16'd4);
    wr(LO_CTRL, 16'h0003); waitn(2);
    v0 = cnt[0]; waitn(128);
    chk("R3 div64 rate", cnt[0] - v0, 16'd2);

    // R4 reserved selects hold on the lower channel
    wr(LO_CTRL, 16'h0005); waitn(1);
    v0 = cnt[0]; waitn(10);
    chk("R4 select 5 holds", cnt[0], v0);
    wr(LO_CTRL, 16'h0007); waitn(1);
    v0 = cnt[0]; waitn(10);
    chk("R4 select 7 holds on lower", cnt[0], v0);

    waitn(8);
    if (sbq.size() != 0) chk("scoreboard drained", 16'(sbq.size()), 16'd0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule